// File: doc/BRIEF.md
# Decimal Carry-Save Column Compressor

This block performs one step of decimal carry-save addition across a row of decimal columns. Each column takes two BCD digits and one unit-weight bit. It returns one BCD digit of the same decimal weight and one carry bit that belongs to the next higher column. A multiplier uses it to reduce three rows of column sums to two. The third row holds only 0s and 1s and enters as the unit bits. The two rows that come out are a BCD digit row and a row of single bits, and a later carry-propagate adder takes them.

Inside each column, a 4-bit carry-lookahead adder first forms the binary sum of the two digits, with the unit bit on its carry input. The result is a 5-bit value of at most 19. The column does not use a +6 correction. One binary-to-decimal cell reads the upper four bits of that value as a digit `d` and the lowest bit as `b`. The cell forms `2d + b`, then splits it into a decimal digit and a carry bit. Each column is fully combinational. Columns do not pass carries to one another within the block.

Top module: `dec_col_compress_row`

## Requirements
- R1: For valid BCD inputs (each digit 0 to 9, packed little-endian with column i in bits [4i+3:4i]), digit output i equals (a_i + b_i + u_i) mod 10.
- R2: Carry output i is 1 exactly when a_i + b_i + u_i is 10 or more.
- R3: For valid BCD inputs, every digit output is a valid BCD digit (0 to 9).
- R4: Each column's outputs depend only on that column's own inputs. Changing one column leaves every other column's outputs unchanged.
- R5: The weighted value of the outputs equals the value of the inputs: the sum over i of (s_i·10^i + c_i·10^(i+1)) equals the sum over i of (a_i + b_i + u_i)·10^i.
- R6: The unit bit enters the binary adder as carry-in with weight one. With a_i + b_i = 9, setting u_i gives digit 0 and carry 1. With a_i = b_i = 0, setting u_i gives digit 1 and carry 0.
- R7: With all inputs zero, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_row | input | 4*NDIG | First BCD digit row, column i at [4i+3:4i] |
| b_row | input | 4*NDIG | Second BCD digit row |
| u_row | input | NDIG | Unit-weight bit row, bit i to column i |
| s_row | output | 4*NDIG | BCD digit row, same weight as inputs |
| c_row | output | NDIG | Carry bits, bit i has the weight of column i+1 |

## Verification
The hardest cases to reach are the ones at the decimal boundary. There, the binary sum sits exactly at 9 or 10, or at the top value 19, and the unit bit alone decides whether a carry appears. The bench sweeps all 200 combinations of two digits and a unit bit through every column. It gives each column a different offset into the sweep, so neighbouring columns see different operands in the same step. A second phase holds all other columns fixed while one column runs through its full range, which shows that no effect crosses between columns.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  localparam int DIG_W = 4;
  localparam int SUM_W = DIG_W + 1;

  typedef logic [DIG_W-1:0] bcd_t;
  typedef logic [SUM_W-1:0] bsum_t;

  // digit is a legal BCD code
  function automatic logic bcd_ok(input bcd_t d);
    return d <= 4'd9;
  endfunction

  // one binary-to-decimal step: v = 2*d + b, split into tens bit and units digit
  function automatic logic [SUM_W-1:0] bd_step(input bcd_t d, input logic b);
    logic [SUM_W-1:0] v;
    logic [SUM_W-1:0] res;
    v = {d, b};
    if (v >= 5'd10) res = {1'b1, 4'(v - 5'd10)};
    else            res = {1'b0, v[DIG_W-1:0]};
    return res;
  endfunction

endpackage

// File: rtl/dcc_cla.sv
module dcc_cla #(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W:0]   sum_o
);

  logic [W-1:0] gen_w;
  logic [W-1:0] prop_w;
  logic [W:0]   carry_w;

  assign gen_w  = x_i & y_i;
  assign prop_w = x_i ^ y_i;

  // flattened sum-of-products lookahead: each carry is formed directly
  always_comb begin
    carry_w[0] = cin_i;
    for (int k = 1; k <= W; k++) begin
      logic acc;
      logic chain;
      chain = cin_i;
      for (int m = 0; m < k; m++) chain = chain & prop_w[m];
      acc = chain;
      for (int j = 0; j < k; j++) begin
        logic prod;
        prod = gen_w[j];
        for (int m = j + 1; m < k; m++) prod = prod & prop_w[m];
        acc = acc | prod;
      end
      carry_w[k] = acc;
    end
  end

  assign sum_o = {carry_w[W], prop_w ^ carry_w[W-1:0]};

  // R6
  always_comb begin
    cla_sum_chk: assert (sum_o == ({1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i}))
      else $error("lookahead sum mismatch");
  end

endmodule

// File: rtl/dcc_bd_cell.sv
module dcc_bd_cell
  import dcc_pkg::*;
(
  input  bcd_t dig_i,
  input  logic bit_i,
  output bcd_t dig_o,
  output logic bit_o
);

  logic [SUM_W-1:0] step_w;

  assign step_w = bd_step(dig_i, bit_i);
  assign bit_o  = step_w[SUM_W-1];
  assign dig_o  = step_w[DIG_W-1:0];

  // R3
  always_comb begin
    if (bcd_ok(dig_i)) begin
      bd_range_chk: assert (bcd_ok(dig_o)) else $error("cell digit out of range");
    end
  end

  // R5
  always_comb begin
    if (bcd_ok(dig_i)) begin
      bd_value_chk: assert ((5'(bit_o) * 5'd10 + 5'(dig_o)) == (5'(dig_i) * 5'd2 + 5'(bit_i)))
        else $error("cell value not preserved");
    end
  end

endmodule

// File: rtl/dcc_column.sv
module dcc_column
  import dcc_pkg::*;
(
  input  bcd_t a_i,
  input  bcd_t b_i,
  input  logic u_i,
  output bcd_t s_o,
  output logic c_o
);

  bsum_t bin_sum_w;
  bcd_t  upper_w;
  logic  lsb_w;

  dcc_cla #(.W(DIG_W)) cla_i (
    .x_i  (a_i),
    .y_i  (b_i),
    .cin_i(u_i),
    .sum_o(bin_sum_w)
  );

  assign upper_w = bin_sum_w[SUM_W-1:1];
  assign lsb_w   = bin_sum_w[0];

  dcc_bd_cell bd_i (
    .dig_i(upper_w),
    .bit_i(lsb_w),
    .dig_o(s_o),
    .bit_o(c_o)
  );

  logic in_ok_w;
  assign in_ok_w = bcd_ok(a_i) && bcd_ok(b_i);

  // R3
  always_comb begin
    if (in_ok_w) begin
      col_upper_chk: assert (bcd_ok(upper_w)) else $error("upper sum bits exceed 9");
    end
  end

  // R2
  always_comb begin
    if (in_ok_w) begin
      col_carry_chk: assert (c_o == (bin_sum_w >= 5'd10)) else $error("column carry wrong");
    end
  end

  // R1
  always_comb begin
    if (in_ok_w) begin
      col_digit_chk: assert ((5'(s_o) + (c_o ? 5'd10 : 5'd0)) == bin_sum_w)
        else $error("column digit wrong");
    end
  end

endmodule

// File: rtl/dec_col_compress_row.sv
module dec_col_compress_row
  import dcc_pkg::*;
#(
  parameter int NDIG = 4
) (
  input  logic [DIG_W*NDIG-1:0] a_row,
  input  logic [DIG_W*NDIG-1:0] b_row,
  input  logic [NDIG-1:0]       u_row,
  output logic [DIG_W*NDIG-1:0] s_row,
  output logic [NDIG-1:0]       c_row
);

  for (genvar i = 0; i < NDIG; i++) begin : g_col
    dcc_column col_i (
      .a_i(a_row[DIG_W*i +: DIG_W]),
      .b_i(b_row[DIG_W*i +: DIG_W]),
      .u_i(u_row[i]),
      .s_o(s_row[DIG_W*i +: DIG_W]),
      .c_o(c_row[i])
    );
  end

  // R7
  always_comb begin
    if (a_row == '0 && b_row == '0 && u_row == '0) begin
      row_zero_chk: assert (s_row == '0 && c_row == '0) else $error("zero in, nonzero out");
    end
  end

endmodule

// File: tb/dec_col_compress_row_tb_top.sv
module dec_col_compress_row_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NDIG = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4*NDIG-1:0] a_row, b_row, s_row;
  logic [NDIG-1:0]   u_row, c_row;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_col_compress_row #(.NDIG(NDIG)) dut_i (
    .a_row(a_row), .b_row(b_row), .u_row(u_row),
    .s_row(s_row), .c_row(c_row)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected values from decimal arithmetic
  function automatic int exp_dig(input int a, input int b, input int u);
    return (a + b + u) % 10;
  endfunction
  function automatic int exp_car(input int a, input int b, input int u);
    return ((a + b + u) >= 10) ? 1 : 0;
  endfunction

  task automatic set_col(input int i, input int a, input int b, input int u);
    a_row[4*i +: 4] = 4'(a);
    b_row[4*i +: 4] = 4'(b);
    u_row[i]        = 1'(u);
  endtask

  task automatic check_all(input string phase);
    int wsum_in;
    int wsum_out;
    int p10;
    wsum_in = 0; wsum_out = 0; p10 = 1;
    for (int i = 0; i < NDIG; i++) begin
      int a; int b; int u; int s; int c;
      a = int'(a_row[4*i +: 4]); b = int'(b_row[4*i +: 4]); u = int'(u_row[i]);
      s = int'(s_row[4*i +: 4]); c = int'(c_row[i]);
      check(s == exp_dig(a, b, u), {phase, " R1 digit"}, s, exp_dig(a, b, u));
      check(c == exp_car(a, b, u), {phase, " R2 carry"}, c, exp_car(a, b, u));
      check(s <= 9, {phase, " R3 bcd"}, s, 9);
      wsum_in  += (a + b + u) * p10;
      wsum_out += s * p10 + c * p10 * 10;
      p10 *= 10;
    end
    check(wsum_out == wsum_in, {phase, " R5 weighted"}, wsum_out, wsum_in);
  endtask

  initial begin
    a_row = '0; b_row = '0; u_row = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: zero inputs give zero outputs
    check(s_row == '0 && c_row == '0, "R7 zero", int'(s_row), 0);

    // exhaustive sweep, each column offset into the 200-case space
    for (int idx = 0; idx < 200; idx++) begin
      @(posedge clk);
      for (int i = 0; i < NDIG; i++) begin
        int k;
        k = (idx + i * 53) % 200;
        set_col(i, k % 10, (k / 10) % 10, k / 100);
      end
      @(negedge clk);
      check_all("sweep");
    end

    // R6: unit bit as carry-in at the decimal boundary
    @(posedge clk);
    set_col(0, 4, 5, 1); set_col(1, 0, 0, 1); set_col(2, 9, 0, 0); set_col(3, 9, 9, 1);
    @(negedge clk);
    check(s_row[3:0] == 4'd0 && c_row[0], "R6 9+u digit/carry", int'(s_row[3:0]), 0);
    check(s_row[7:4] == 4'd1 && !c_row[1], "R6 0+0+u", int'(s_row[7:4]), 1);
    check(s_row[11:8] == 4'd9 && !c_row[2], "R6 9 no u", int'(s_row[11:8]), 9);
    check(s_row[15:12] == 4'd9 && c_row[3], "R6 19 max", int'(s_row[15:12]), 9);

    // R4: hold columns 1..NDIG-1, sweep column 0, neighbours stay fixed
    for (int idx = 0; idx < 200; idx++) begin
      @(posedge clk);
      for (int i = 1; i < NDIG; i++) set_col(i, 9 - i, i + 3, i % 2);
      set_col(0, idx % 10, (idx / 10) % 10, idx / 100);
      @(negedge clk);
      check_all("hold");
      for (int i = 1; i < NDIG; i++) begin
        int e;
        e = exp_dig(9 - i, i + 3, i % 2) + 10 * exp_car(9 - i, i + 3, i % 2);
        check((int'(s_row[4*i +: 4]) + 10 * int'(c_row[i])) == e,
              "R4 neighbour unchanged", int'(s_row[4*i +: 4]) + 10 * int'(c_row[i]), e);
      end
    end

    done = 1'b1;
  end

  initial begin : watchdog
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule